// File: doc/BRIEF.md
# Interrupt Eligibility and Cause Selector

This block decides, on every cycle, whether the hart should accept an interrupt and which one. It holds the interrupt enable and delegation registers, the software-set pending bits and a memory-mapped machine software pending bit. It merges these with raw timer, external and coprocessor request levels into a single pending vector.

Each candidate (a bit that is both pending and enabled) is gated by one of two privilege domains. Candidates that are not delegated answer to the machine domain. Delegated candidates answer to the supervisor domain. Among the candidates that survive the gating, the lowest-numbered bit is chosen.

The decision is purely combinational from the register state and the input levels. The take strobe is offered only while the pipeline signals an instruction boundary. The surrounding trap logic consumes the strobe together with a cause word whose top bit marks it as an interrupt.

Top module: `irq_take_unit`

## Requirements
- R1: After reset the software pending bits, the machine software pending bit, the enable register and the delegation register all read zero, and take_o is low.
- R2: pend_o holds supervisor software pending at bit 1, machine software pending at bit 3, supervisor timer pending at bit 5, the machine timer line at bit 7, the supervisor external line at bit 9 and the coprocessor line at bit COP_BIT (12 by default); every other bit reads zero.
- R3: A register write with csr_tgt_i = 0 loads only pending bits 1 and 5 from csr_wdata_i on the next clock; all other pending bits are unaffected.
- R4: A register write with csr_tgt_i = 1 loads the enable register from csr_wdata_i masked to bits 1, 3, 5, 7, 9 and COP_BIT; without such a write the enable register holds.
- R5: A register write with csr_tgt_i = 2 loads the delegation register from csr_wdata_i masked to bits 1, 5, 9 and COP_BIT; without such a write it holds; csr_tgt_i = 3 changes no register.
- R6: A store with sw_st_we_i high and sw_st_addr_i equal to zero sets pending bit 3 to sw_st_bit_i on the next clock; a store to any other offset leaves it unchanged.
- R7: A non-delegated candidate is eligible when priv_i is below machine (priv encoding 0 = user, 1 = supervisor, 2 = treated as user, 3 = machine), or when priv_i is machine and m_gie_i is high.
- R8: A delegated candidate is eligible when priv_i is user (0 or 2), or when priv_i is supervisor and s_gie_i is high; at machine privilege a delegated candidate is never taken.
- R9: When several candidates are eligible, the lowest bit index wins.
- R10: While take_o is high, cause_o has bit XLEN-1 set, the winning index in its low bits and zeros elsewhere; while take_o is low, cause_o is zero.
- R11: take_o is high only when some candidate is eligible and insn_boundary_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege level |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| line_mtimer_i | input | 1 | Raw machine timer request level |
| line_sext_i | input | 1 | Raw supervisor external request level |
| line_cop_i | input | 1 | Raw coprocessor request level |
| csr_we_i | input | 1 | Register write strobe |
| csr_tgt_i | input | 2 | Write target: 0 pending, 1 enable, 2 delegation, 3 none |
| csr_wdata_i | input | NIRQ | Register write data |
| sw_st_we_i | input | 1 | Memory-mapped store strobe |
| sw_st_addr_i | input | ADDR_W | Memory-mapped store offset |
| sw_st_bit_i | input | 1 | Bit 0 of the store data |
| insn_boundary_i | input | 1 | High between instructions |
| pend_o | output | NIRQ | Merged pending vector |
| enab_o | output | NIRQ | Enable register |
| deleg_o | output | NIRQ | Delegation register |
| take_o | output | 1 | Accept-interrupt strobe |
| cause_o | output | XLEN | Interrupt cause word |

## Verification
The bench builds the block with its defaults: XLEN = 32, NIRQ = 16, COP_BIT = 12 and ADDR_W = 12. A 16-bit vector places all six interrupt sources, including the coprocessor bit above the external bit, where random writes with every data bit toggling probe each write mask in full. A 12-bit store offset lets random stores land on both the active offset and the many ignored ones. All four privilege encodings are exercised against both global enables and arbitrary delegation patterns.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TGT_PEND  = 2'd0,
    TGT_ENAB  = 2'd1,
    TGT_DELEG = 2'd2,
    TGT_NONE  = 2'd3
  } csr_tgt_e;

  localparam int unsigned POS_SSW = 1;
  localparam int unsigned POS_MSW = 3;
  localparam int unsigned POS_STM = 5;
  localparam int unsigned POS_MTM = 7;
  localparam int unsigned POS_SEX = 9;

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_sel_pkg::*;
#(
  parameter int unsigned NIRQ    = 16,
  parameter int unsigned COP_BIT = 12,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  csr_tgt_e          csr_tgt,
  input  logic [NIRQ-1:0]   csr_wdata,
  input  logic              st_we,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_bit,
  input  logic              line_mtimer,
  input  logic              line_sext,
  input  logic              line_cop,
  output logic [NIRQ-1:0]   pend,
  output logic [NIRQ-1:0]   enab,
  output logic [NIRQ-1:0]   deleg
);

  localparam logic [NIRQ-1:0] ONE       = {{(NIRQ-1){1'b0}}, 1'b1};
  localparam logic [NIRQ-1:0] M_SSW     = ONE << POS_SSW;
  localparam logic [NIRQ-1:0] M_MSW     = ONE << POS_MSW;
  localparam logic [NIRQ-1:0] M_STM     = ONE << POS_STM;
  localparam logic [NIRQ-1:0] M_MTM     = ONE << POS_MTM;
  localparam logic [NIRQ-1:0] M_SEX     = ONE << POS_SEX;
  localparam logic [NIRQ-1:0] M_COP     = ONE << COP_BIT;
  localparam logic [NIRQ-1:0] DLG_MASK  = M_SSW | M_STM | M_SEX | M_COP;
  localparam logic [NIRQ-1:0] ENB_MASK  = DLG_MASK | M_MSW | M_MTM;
  localparam logic [NIRQ-1:0] SWP_MASK  = M_SSW | M_STM;

  logic [NIRQ-1:0] swp_q, swp_d;
  logic            msw_q, msw_d;
  logic [NIRQ-1:0] enab_q, enab_d;
  logic [NIRQ-1:0] deleg_q, deleg_d;
  logic            swp_en, enab_en, deleg_en, msw_en;

  always_comb begin
    swp_en   = csr_we && (csr_tgt == TGT_PEND);
    enab_en  = csr_we && (csr_tgt == TGT_ENAB);
    deleg_en = csr_we && (csr_tgt == TGT_DELEG);
    msw_en   = st_we && (st_addr == '0);
    swp_d    = csr_wdata & SWP_MASK;
    enab_d   = csr_wdata & ENB_MASK;
    deleg_d  = csr_wdata & DLG_MASK;
    msw_d    = st_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swp_q   <= '0;
      msw_q   <= 1'b0;
      enab_q  <= '0;
      deleg_q <= '0;
    end else begin
      if (swp_en)   swp_q   <= swp_d;
      if (msw_en)   msw_q   <= msw_d;
      if (enab_en)  enab_q  <= enab_d;
      if (deleg_en) deleg_q <= deleg_d;
    end
  end

  always_comb begin
    pend = swp_q;
    pend[POS_MSW] = msw_q;
    pend[POS_MTM] = line_mtimer;
    pend[POS_SEX] = line_sext;
    pend[COP_BIT] = line_cop;
    enab  = enab_q;
    deleg = deleg_q;
  end

  AST_SWP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && csr_tgt == TGT_PEND) |=> $stable(swp_q)); // R3
  AST_ENAB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && csr_tgt == TGT_ENAB) |=> $stable(enab)); // R4
  AST_DELEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && csr_tgt == TGT_DELEG) |=> $stable(deleg)); // R5
  AST_MSW_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_addr == '0) |=> (pend[POS_MSW] == $past(st_bit))); // R6
  AST_MSW_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_we && st_addr == '0) |=> $stable(msw_q)); // R6

endmodule

// File: rtl/irq_domain_gate.sv
module irq_domain_gate
  import irq_sel_pkg::*;
#(
  parameter int unsigned NIRQ = 16
) (
  input  priv_e           priv,
  input  logic            m_gie,
  input  logic            s_gie,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] enab,
  input  logic [NIRQ-1:0] deleg,
  output logic [NIRQ-1:0] elig
);

  logic            m_open, s_open, below_s;
  logic [NIRQ-1:0] cand;

  always_comb begin
    below_s = (priv == PRIV_USER) || (priv == PRIV_RSVD);
    m_open  = (priv != PRIV_MACH) || m_gie;
    s_open  = below_s || ((priv == PRIV_SUPV) && s_gie);
    cand    = pend & enab;
    elig    = (cand & ~deleg & {NIRQ{m_open}})
            | (cand &  deleg & {NIRQ{s_open}});
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NIRQ  = 16,
  parameter int unsigned IDX_W = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0]  elig,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_take_unit.sv
module irq_take_unit
  import irq_sel_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NIRQ    = 16,
  parameter int unsigned COP_BIT = 12,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        priv_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic              line_mtimer_i,
  input  logic              line_sext_i,
  input  logic              line_cop_i,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_tgt_i,
  input  logic [NIRQ-1:0]   csr_wdata_i,
  input  logic              sw_st_we_i,
  input  logic [ADDR_W-1:0] sw_st_addr_i,
  input  logic              sw_st_bit_i,
  input  logic              insn_boundary_i,
  output logic [NIRQ-1:0]   pend_o,
  output logic [NIRQ-1:0]   enab_o,
  output logic [NIRQ-1:0]   deleg_o,
  output logic              take_o,
  output logic [XLEN-1:0]   cause_o
);

  localparam int unsigned IDX_W = $clog2(NIRQ);

  logic [NIRQ-1:0]  pend_w, enab_w, deleg_w, elig_w;
  logic             found_w;
  logic [IDX_W-1:0] idx_w;
  priv_e            priv_w;

  assign priv_w = priv_e'(priv_i);

  irq_src_regs #(
    .NIRQ(NIRQ), .COP_BIT(COP_BIT), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we_i), .csr_tgt(csr_tgt_e'(csr_tgt_i)), .csr_wdata(csr_wdata_i),
    .st_we(sw_st_we_i), .st_addr(sw_st_addr_i), .st_bit(sw_st_bit_i),
    .line_mtimer(line_mtimer_i), .line_sext(line_sext_i), .line_cop(line_cop_i),
    .pend(pend_w), .enab(enab_w), .deleg(deleg_w)
  );

  irq_domain_gate #(.NIRQ(NIRQ)) u_gate (
    .priv(priv_w), .m_gie(m_gie_i), .s_gie(s_gie_i),
    .pend(pend_w), .enab(enab_w), .deleg(deleg_w), .elig(elig_w)
  );

  irq_lowest_pick #(.NIRQ(NIRQ), .IDX_W(IDX_W)) u_pick (
    .elig(elig_w), .found(found_w), .idx(idx_w)
  );

  always_comb begin
    take_o  = found_w && insn_boundary_i;
    cause_o = '0;
    if (take_o) begin
      cause_o[XLEN-1]    = 1'b1;
      cause_o[IDX_W-1:0] = idx_w;
    end
    pend_o  = pend_w;
    enab_o  = enab_w;
    deleg_o = deleg_w;
  end

  AST_TAKE_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pend_w[cause_o[IDX_W-1:0]] && enab_w[cause_o[IDX_W-1:0]])); // R9
  AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cause_o[XLEN-1] && (cause_o[XLEN-2:IDX_W] == '0))); // R10
  AST_NO_M_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_o && priv_w == PRIV_MACH && !m_gie_i)); // R7
  AST_NO_DELEG_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && priv_w == PRIV_MACH) |-> !deleg_w[cause_o[IDX_W-1:0]]); // R8
  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> insn_boundary_i); // R11

endmodule

// File: tb/irq_take_unit_tb.sv
`timescale 1ns/1ps
module irq_take_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  priv_i;
  logic        m_gie_i, s_gie_i;
  logic        line_mtimer_i, line_sext_i, line_cop_i;
  logic        csr_we_i;
  logic [1:0]  csr_tgt_i;
  logic [15:0] csr_wdata_i;
  logic        sw_st_we_i;
  logic [11:0] sw_st_addr_i;
  logic        sw_st_bit_i;
  logic        insn_boundary_i;
  logic [15:0] pend_o, enab_o, deleg_o;
  logic        take_o;
  logic [31:0] cause_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        m_ssw, m_stm, m_msw;
  logic [15:0] m_enab, m_deleg;

  always #2.5 clk = ~clk;

  irq_take_unit u_dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
    .line_mtimer_i(line_mtimer_i), .line_sext_i(line_sext_i), .line_cop_i(line_cop_i),
    .csr_we_i(csr_we_i), .csr_tgt_i(csr_tgt_i), .csr_wdata_i(csr_wdata_i),
    .sw_st_we_i(sw_st_we_i), .sw_st_addr_i(sw_st_addr_i), .sw_st_bit_i(sw_st_bit_i),
    .insn_boundary_i(insn_boundary_i), .pend_o(pend_o), .enab_o(enab_o),
    .deleg_o(deleg_o), .take_o(take_o), .cause_o(cause_o)
  );

  // behavioural reference state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ssw = 0; m_stm = 0; m_msw = 0; m_enab = 0; m_deleg = 0;
    end else begin
      if (csr_we_i && csr_tgt_i == 2'd0) begin
        m_ssw = csr_wdata_i[1]; m_stm = csr_wdata_i[5];
      end
      if (csr_we_i && csr_tgt_i == 2'd1) m_enab  = csr_wdata_i & 16'h12AA;
      if (csr_we_i && csr_tgt_i == 2'd2) m_deleg = csr_wdata_i & 16'h1222;
      if (sw_st_we_i && sw_st_addr_i == 12'd0) m_msw = sw_st_bit_i;
    end
  end

  function automatic logic [15:0] exp_pend();
    logic [15:0] p = 0;
    p[1] = m_ssw; p[3] = m_msw; p[5] = m_stm;
    p[7] = line_mtimer_i; p[9] = line_sext_i; p[12] = line_cop_i;
    return p;
  endfunction

  function automatic logic [31:0] exp_cause();
    logic [15:0] p = exp_pend();
    bit m_ok = (priv_i != 2'd3) || m_gie_i;
    bit s_ok = (priv_i == 2'd0) || (priv_i == 2'd2) || (priv_i == 2'd1 && s_gie_i);
    if (!insn_boundary_i) return 32'd0;
    for (int i = 0; i < 16; i++) begin
      if (p[i] && m_enab[i] && (m_deleg[i] ? s_ok : m_ok))
        return 32'h8000_0000 | i;
    end
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic [31:0] ec = exp_cause();
    chk("R2 R3 R6 pending", {16'd0, pend_o}, {16'd0, exp_pend()});
    chk("R4 enable", {16'd0, enab_o}, {16'd0, m_enab});
    chk("R5 delegation", {16'd0, deleg_o}, {16'd0, m_deleg});
    chk("R7 R8 R11 take", {31'd0, take_o}, {31'd0, ec[31]});
    chk("R9 R10 cause", cause_o, ec);
  endtask

  task automatic quiet();
    csr_we_i = 0; csr_tgt_i = 2'd3; csr_wdata_i = 0;
    sw_st_we_i = 0; sw_st_addr_i = 0; sw_st_bit_i = 0;
  endtask

  task automatic step();
    @(negedge clk); #1; cmp_all();
  endtask

  task automatic wr(logic [1:0] tgt, logic [15:0] d);
    @(negedge clk); csr_we_i = 1; csr_tgt_i = tgt; csr_wdata_i = d; #1; cmp_all();
    @(negedge clk); quiet(); #1; cmp_all();
  endtask

  task automatic st(logic [11:0] a, logic b);
    @(negedge clk); sw_st_we_i = 1; sw_st_addr_i = a; sw_st_bit_i = b; #1; cmp_all();
    @(negedge clk); quiet(); #1; cmp_all();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 0; quiet();
    priv_i = 2'd3; m_gie_i = 0; s_gie_i = 0;
    line_mtimer_i = 0; line_sext_i = 0; line_cop_i = 0; insn_boundary_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk("R1 pend", {16'd0, pend_o}, 32'd0);
    chk("R1 enab", {16'd0, enab_o}, 32'd0);
    chk("R1 deleg", {16'd0, deleg_o}, 32'd0);
    chk("R1 take", {31'd0, take_o}, 32'd0);

    // R4 / R5 / R3 masks with all-ones data
    wr(2'd1, 16'hFFFF);
    chk("R4 enable mask", {16'd0, enab_o}, 32'h12AA);
    wr(2'd2, 16'hFFFF);
    chk("R5 deleg mask", {16'd0, deleg_o}, 32'h1222);
    wr(2'd0, 16'hFFFF);
    chk("R3 pending mask", {16'd0, pend_o}, 32'h0022);
    wr(2'd3, 16'h0000);
    chk("R5 none target", {16'd0, deleg_o}, 32'h1222);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);

    // R6 store offset handling
    st(12'd4, 1'b1);
    chk("R6 other offset", {31'd0, pend_o[3]}, 32'd0);
    st(12'd0, 1'b1);
    chk("R6 msw set", {31'd0, pend_o[3]}, 32'd1);

    // R7 machine gating of MSW (bit 3, enabled, not delegated)
    priv_i = 2'd3; m_gie_i = 0; step();
    chk("R7 masked in M", {31'd0, take_o}, 32'd0);
    m_gie_i = 1; step();
    chk("R7 open in M", cause_o, 32'h8000_0003);
    st(12'd0, 1'b0);

    // R8 delegated SSW
    wr(2'd2, 16'h0002);
    wr(2'd0, 16'h0002);
    step();
    chk("R8 deleg in M", {31'd0, take_o}, 32'd0);
    priv_i = 2'd1; s_gie_i = 0; step();
    chk("R8 S closed", {31'd0, take_o}, 32'd0);
    s_gie_i = 1; step();
    chk("R8 S open", cause_o, 32'h8000_0001);

    // R9 lowest wins, R11 boundary
    wr(2'd2, 16'h0000);
    st(12'd0, 1'b1);
    line_sext_i = 1; priv_i = 2'd0; step();
    chk("R9 lowest", cause_o, 32'h8000_0001);
    insn_boundary_i = 0; step();
    chk("R11 no boundary take", {31'd0, take_o}, 32'd0);
    chk("R10 cause zero", cause_o, 32'd0);
    insn_boundary_i = 1;

    // random phase
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      priv_i          = 2'($urandom);
      m_gie_i         = 1'($urandom);
      s_gie_i         = 1'($urandom);
      line_mtimer_i   = 1'($urandom);
      line_sext_i     = 1'($urandom);
      line_cop_i      = 1'($urandom);
      insn_boundary_i = ($urandom % 4) != 0;
      csr_we_i        = ($urandom % 3) == 0;
      csr_tgt_i       = 2'($urandom);
      csr_wdata_i     = 16'($urandom);
      sw_st_we_i      = ($urandom % 4) == 0;
      sw_st_addr_i    = (($urandom % 2) == 0) ? 12'd0 : 12'($urandom);
      sw_st_bit_i     = 1'($urandom);
      #1; cmp_all();
    end
    finish_up();
  end

endmodule